// File: doc/BRIEF.md
# Gated Programmable Rate Generator

This block is one counter/timer channel working as a clock divider. Once started, it produces a continuous pulse train. Each period lasts a programmed number of counting ticks, the divisor. The active part of each period is a programmed percentage of the divisor. A tick is either every cycle of the system clock, or one rising edge of an external clock input after that input has been synchronized. The train can be paced by a level-sensitive gate, and its output polarity is selectable.

Configuration is loaded with a one-cycle write strobe. The block accepts a write only while the channel is stopped, and only if the values are legal. While the channel is disabled, the output rests at its inactive level. Each time the channel is enabled again, the period restarts from the beginning of the active phase.

Top module: `gated_rate_gen`

## Requirements
- R1: While enabled, the output period is exactly `divisor` ticks. With the internal source, one tick is one `clk` cycle.
- R2: The number of active ticks per period is floor(divisor × percent / 100), limited to the range 1 to divisor−1. Examples: divisor 10 at 20 % gives 2; divisor 4 at 0 % gives 1; divisor 4 at 100 % gives 3.
- R3: `cfg_gate_mode` selects the gate as follows: 0 = software (always open), 1 = external gate open while high, 2 = external gate open while low. Code 3 is illegal.
- R4: With the software gate, the output is active in the first cycle after the `start` edge, and the pattern repeats from there.
- R5: With an external gate, `gate_in` passes through a two-flop synchronizer. Pulses appear two cycles after the gate reaches its active level. The output returns to inactive two cycles after the gate leaves that level.
- R6: While the channel is not running or the gate is closed, the output is at its inactive level. `stop` takes the output inactive in the next cycle, and `stop` wins over a simultaneous `start`.
- R7: With `cfg_active_low` = 0, active is high and inactive is low. With `cfg_active_low` = 1, active is low and inactive is high.
- R8: With `cfg_ext_clk` = 1, the counter advances once per rising edge of `ext_clk_in`. That edge takes effect three `clk` edges after it is sampled: two synchronizer flops, then an edge-detect flop.
- R9: A configuration write is ignored if the divisor is below 2, if the gate code is 3, or if the channel is running. In each case the previously loaded configuration stays in force.
- R10: On every re-enable, whether after `start` or after the gate reopens, the phase counter restarts at zero, so the first cycle is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (internal tick source) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_write | input | 1 | One-cycle configuration load strobe |
| cfg_divisor | input | CNT_W | Ticks per output period |
| cfg_percent | input | 7 | Active width as a percentage of the period |
| cfg_gate_mode | input | 2 | Gate selection (0 software, 1 high, 2 low) |
| cfg_ext_clk | input | 1 | 1 = count external clock edges |
| cfg_active_low | input | 1 | 1 = active portion is low |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse |
| gate_in | input | 1 | External gate, asynchronous |
| ext_clk_in | input | 1 | External clock, asynchronous |
| pulse_out | output | 1 | Pulse train output |

## Verification
The assertions assume three things about the inputs. The external clock and gate are slow compared with `clk`, so every level is held for several cycles. `start` and `stop` are single-cycle strobes. Configuration is written only through `cfg_write`. The stimulus changes every input on the falling clock edge. It holds each `ext_clk_in` level for four system cycles, and it keeps gate levels for many cycles, so each change crosses the synchronizer cleanly and the expected latency is deterministic. An illegal or mid-run configuration write is always followed by a measured waveform, so a write that was wrongly accepted shows up as a wrong period or a wrong width.

// File: rtl/rg_pkg.sv
// Shared definitions for the gated rate generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rg_pkg;
    // Width of the percentage field (0..127, values above 100 clamp)
    localparam int PCT_W = 7;

    // Gate selection codes
    typedef enum logic [1:0] {
        GATE_SW  = 2'd0,
        GATE_HI  = 2'd1,
        GATE_LO  = 2'd2,
        GATE_BAD = 2'd3
    } gate_mode_e;
endpackage

// File: rtl/rg_sync.sv
// Multi-stage synchronizer for asynchronous single-bit inputs.
// Assumes each input level is held for more than STAGES clock cycles.
module rg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rg_cfg.sv
// Configuration holding register. Validates a write, computes the active
// tick count from divisor and percentage, and freezes while running.
// Assumes cfg_write is a one-cycle strobe.
module rg_cfg #(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic                     running,
    input  logic [CNT_W-1:0]         div_in,
    input  logic [rg_pkg::PCT_W-1:0] pct_in,
    input  logic [1:0]               mode_in,
    input  logic                     ext_in,
    input  logic                     pol_in,
    output logic [CNT_W-1:0]         div_q,
    output logic [CNT_W-1:0]         act_q,
    output rg_pkg::gate_mode_e       mode_q,
    output logic                     ext_q,
    output logic                     pol_q
);
    import rg_pkg::*;

    localparam int PW = CNT_W + PCT_W;

    logic [PW-1:0]    prod;
    logic [PW-1:0]    quo;
    logic [CNT_W-1:0] act_calc;
    logic             accept;

    // Active tick count: floor(div*pct/100), limited to 1..div-1
    always_comb begin
        prod = PW'(div_in) * PW'(pct_in);
        quo  = prod / PW'(100);
        if (quo < PW'(1))
            act_calc = CNT_W'(1);
        else if (quo >= PW'(div_in))
            act_calc = div_in - CNT_W'(1);
        else
            act_calc = quo[CNT_W-1:0];
    end

    // A write is taken only when stopped and legal
    assign accept = wr && !running && (div_in >= CNT_W'(2))
                    && (mode_in != GATE_BAD);

    // Hold the active configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= CNT_W'(2);
            act_q  <= CNT_W'(1);
            mode_q <= GATE_SW;
            ext_q  <= 1'b0;
            pol_q  <= 1'b0;
        end else if (accept) begin
            div_q  <= div_in;
            act_q  <= act_calc;
            mode_q <= gate_mode_e'(mode_in);
            ext_q  <= ext_in;
            pol_q  <= pol_in;
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(div_q) && $stable(act_q) && $stable(pol_q)));

    // R2
    act_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q >= CNT_W'(1)) && (act_q < div_q));
endmodule

// File: rtl/rg_phase.sv
// Phase counter and output shaper. Counts ticks modulo the divisor while
// live, marks the first act ticks as active and applies polarity.
// Assumes div and act stay constant while live is high.
module rg_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic             tick,
    input  logic [CNT_W-1:0] div,
    input  logic [CNT_W-1:0] act,
    input  logic             pol,
    output logic             pulse_out
);
    logic [CNT_W-1:0] cnt;
    logic             active;

    // Advance the phase on each tick, reload to zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !live)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == div - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
    end

    // Active portion and polarity
    assign active    = live && (cnt < act);
    assign pulse_out = active ^ pol;

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < div);

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (pulse_out == pol));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live) |-> (pulse_out != pol));
endmodule

// File: rtl/gated_rate_gen.sv
// Gated programmable rate generator: one counter channel in clock-divider
// mode. Holds run state, synchronizes gate and external clock, selects the
// tick source and enables the phase counter.
// Assumes start/stop are one-cycle strobes; async inputs change slowly.
module gated_rate_gen #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_write,
    input  logic [CNT_W-1:0]         cfg_divisor,
    input  logic [rg_pkg::PCT_W-1:0] cfg_percent,
    input  logic [1:0]               cfg_gate_mode,
    input  logic                     cfg_ext_clk,
    input  logic                     cfg_active_low,
    input  logic                     start,
    input  logic                     stop,
    input  logic                     gate_in,
    input  logic                     ext_clk_in,
    output logic                     pulse_out
);
    import rg_pkg::*;

    logic             run;
    logic             gate_s;
    logic             eclk_s;
    logic             eclk_prev;
    logic             tick;
    logic             gate_ok;
    logic             live;
    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] act_q;
    gate_mode_e       mode_q;
    logic             ext_q;
    logic             pol_q;

    rg_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_write),
        .running (run),
        .div_in  (cfg_divisor),
        .pct_in  (cfg_percent),
        .mode_in (cfg_gate_mode),
        .ext_in  (cfg_ext_clk),
        .pol_in  (cfg_active_low),
        .div_q   (div_q),
        .act_q   (act_q),
        .mode_q  (mode_q),
        .ext_q   (ext_q),
        .pol_q   (pol_q)
    );

    rg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({gate_in, ext_clk_in}),
        .q     ({gate_s, eclk_s})
    );

    // Run state: stop has priority over start
    always_ff @(posedge clk) begin
        if (!rst_n || stop) run <= 1'b0;
        else if (start)     run <= 1'b1;
    end

    // Previous synchronized external clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) eclk_prev <= 1'b0;
        else        eclk_prev <= eclk_s;
    end

    // Tick source selection
    assign tick = ext_q ? (eclk_s && !eclk_prev) : 1'b1;

    // Gate evaluation per mode
    always_comb begin
        case (mode_q)
            GATE_HI: gate_ok = gate_s;
            GATE_LO: gate_ok = !gate_s;
            default: gate_ok = 1'b1;
        endcase
    end

    assign live = run && gate_ok;

    rg_phase #(.CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .tick      (tick),
        .div       (div_q),
        .act       (act_q),
        .pol       (pol_q),
        .pulse_out (pulse_out)
    );

    // R6
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !run);

    // R3
    gate_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != GATE_BAD);

    // R8
    ext_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q && tick) |=> !tick);
endmodule

// File: tb/gated_rate_gen_tb.sv
// Directed bench for gated_rate_gen. Inputs change and outputs are
// sampled on the falling clock edge.
module gated_rate_gen_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_write = 1'b0;
    logic [CNT_W-1:0] cfg_divisor = '0;
    logic [6:0]       cfg_percent = '0;
    logic [1:0]       cfg_gate_mode = '0;
    logic             cfg_ext_clk = 1'b0;
    logic             cfg_active_low = 1'b0;
    logic             start = 1'b0;
    logic             stop = 1'b0;
    logic             gate_in = 1'b0;
    logic             ext_clk_in = 1'b0;
    logic             pulse_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gated_rate_gen #(.CNT_W(CNT_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_write      (cfg_write),
        .cfg_divisor    (cfg_divisor),
        .cfg_percent    (cfg_percent),
        .cfg_gate_mode  (cfg_gate_mode),
        .cfg_ext_clk    (cfg_ext_clk),
        .cfg_active_low (cfg_active_low),
        .start          (start),
        .stop           (stop),
        .gate_in        (gate_in),
        .ext_clk_in     (ext_clk_in),
        .pulse_out      (pulse_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic act_v, input logic exp_v, input string tag);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: pulse_out=%0b expected %0b at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic write_cfg(input int dv, input int pc, input int md,
                             input bit ex, input bit pl);
        cfg_divisor    = CNT_W'(dv);
        cfg_percent    = 7'(pc);
        cfg_gate_mode  = 2'(md);
        cfg_ext_clk    = ex;
        cfg_active_low = pl;
        cfg_write = 1'b1;
        @(negedge clk);
        cfg_write = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    // Samples n points of the expected pattern, first one now
    task automatic check_wave(input int dv, input int ac, input bit pl,
                              input int first, input int n, input string tag);
        for (int i = first; i < first + n; i++) begin
            chk(pulse_out, logic'(((i % dv) < ac) ^ pl), tag);
            @(negedge clk);
        end
    endtask

    task automatic check_const(input logic v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(pulse_out, v, tag);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check_const(1'b0, 4, "R6 reset idle low");
    endtask

    task automatic t_software_gate();
        write_cfg(10, 20, 0, 1'b0, 1'b0);
        do_start();
        check_wave(10, 2, 1'b0, 0, 30, "R1 R2 R4 div10 20pct");
        do_stop();
        check_const(1'b0, 5, "R6 stop idle");
        do_start();
        check_wave(10, 2, 1'b0, 0, 12, "R10 restart after stop");
        stop = 1'b1; start = 1'b1;
        @(negedge clk);
        stop = 1'b0; start = 1'b0;
        check_const(1'b0, 4, "R6 stop wins over start");
    endtask

    task automatic t_clamp();
        write_cfg(4, 0, 0, 1'b0, 1'b0);
        do_start();
        check_wave(4, 1, 1'b0, 0, 12, "R2 clamp low to 1");
        do_stop();
        write_cfg(4, 100, 0, 1'b0, 1'b0);
        do_start();
        check_wave(4, 3, 1'b0, 0, 12, "R2 clamp high to div-1");
        do_stop();
    endtask

    task automatic t_polarity();
        write_cfg(5, 40, 0, 1'b0, 1'b1);
        check_const(1'b1, 3, "R7 idle high when active low");
        do_start();
        check_wave(5, 2, 1'b1, 0, 15, "R7 active low wave");
        do_stop();
        check_const(1'b1, 3, "R7 R6 idle after stop");
    endtask

    task automatic t_reject();
        write_cfg(6, 50, 0, 1'b0, 1'b0);
        do_start();
        check_wave(6, 3, 1'b0, 0, 12, "R9 base wave");
        write_cfg(10, 20, 0, 1'b0, 1'b1);
        check_wave(6, 3, 1'b0, 13, 12, "R9 write while running ignored");
        do_stop();
        write_cfg(1, 50, 0, 1'b0, 1'b0);
        do_start();
        check_wave(6, 3, 1'b0, 0, 12, "R9 divisor 1 rejected");
        do_stop();
        write_cfg(8, 50, 3, 1'b0, 1'b1);
        do_start();
        check_wave(6, 3, 1'b0, 0, 12, "R3 R9 gate code 3 rejected");
        do_stop();
    endtask

    task automatic t_gate_high();
        gate_in = 1'b0;
        write_cfg(4, 50, 1, 1'b0, 1'b0);
        do_start();
        check_const(1'b0, 5, "R5 gate closed no pulses");
        gate_in = 1'b1;
        @(negedge clk);
        chk(pulse_out, 1'b0, "R5 sync latency");
        @(negedge clk);
        check_wave(4, 2, 1'b0, 0, 10, "R5 gate open high");
        gate_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_const(1'b0, 5, "R5 gate closed again");
        gate_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_wave(4, 2, 1'b0, 0, 8, "R10 gate reopen restarts");
        do_stop();
        gate_in = 1'b0;
    endtask

    task automatic t_gate_low();
        gate_in = 1'b1;
        write_cfg(3, 67, 2, 1'b0, 1'b0);
        do_start();
        check_const(1'b0, 5, "R3 low gate closed while high");
        gate_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_wave(3, 2, 1'b0, 0, 9, "R3 R5 low gate open");
        do_stop();
    endtask

    task automatic t_ext_clock();
        int ph = 0;
        ext_clk_in = 1'b0;
        write_cfg(3, 34, 0, 1'b1, 1'b0);
        do_start();
        for (int k = 0; k < 6; k++) begin
            ext_clk_in = 1'b1;
            for (int s = 0; s < 4; s++) begin
                if (s == 3) ph = (ph + 1) % 3;
                chk(pulse_out, logic'(ph < 1), "R8 external tick");
                @(negedge clk);
            end
            ext_clk_in = 1'b0;
            for (int s = 0; s < 4; s++) begin
                chk(pulse_out, logic'(ph < 1), "R8 hold between edges");
                @(negedge clk);
            end
        end
        do_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_software_gate();
        t_clamp();
        t_polarity();
        t_reject();
        t_gate_high();
        t_gate_low();
        t_ext_clock();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule